// File: doc/BRIEF.md
# Multi-cycle RISC datapath

This block is the datapath of a 32-bit load/store processor that spends several clock cycles on each instruction. It holds the program counter, an instruction register, a branch-target register and a 32-entry register file. It also holds three holding registers that capture the two register operands and the ALU result on every cycle.

One ALU is used at different times for three jobs:
- advancing the PC during fetch,
- forming the branch target during decode,
- executing the instruction.

One memory port, which lives outside the block, serves both instruction fetch and data access.

The block has no sequencer of its own. An external controller drives every multiplexer select and every write enable on each cycle. The block returns the opcode and function fields of the held instruction and the ALU zero flag, so the controller can choose its next step. The supported instructions are register-register arithmetic, or-immediate, load word, store word and branch-if-equal.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high reset clears the PC and the instruction register to zero, so the memory address (with address select 0), opcode and function outputs all read 0.
- R2: The instruction register loads memory read data only in a cycle with its write enable high, and otherwise holds. Opcode is bits 31:26, rs bits 25:21, rt bits 20:16, rd bits 15:11, function bits 5:0 and the immediate bits 15:0.
- R3: ALU input A is the PC when its select is 0 and held operand A when it is 1. Input B is chosen by a 2-bit select: 00 the constant 4, 01 held operand B, 10 the sign-extended immediate shifted left by two, 11 the extended immediate.
- R4: With the extend control at 1 the immediate is sign-extended; with it at 0 it is zero-extended.
- R5: The branch-target register captures the ALU result only in cycles with its write enable high.
- R6: The PC is written when the unconditional enable is high, or when the conditional enable is high and the zero flag is 1. Its source is the ALU result (select 0) or the branch-target register (select 1).
- R7: A register write goes to rd when the destination select is 1 and to rt when it is 0. The data is the held ALU result (data select 0) or the memory read data (select 1).
- R8: The memory address is the PC with address select 0 and the held ALU result with select 1. The memory write data is held operand B, which is register rt.
- R9: Writes to register 0 are discarded, and register 0 always reads as zero.
- R10: ALU mode 00 adds, 01 subtracts, 10 ORs. Mode 11 decodes the function field: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. The zero flag is 1 exactly when the ALU result is 0.
- R11: The held operands and the held ALU result are reloaded on every clock, so an ALU result shows up on the memory address one cycle after it is computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_we | input | 1 | Unconditional PC write enable |
| pc_we_cond | input | 1 | PC write enable qualified by the zero flag |
| pc_src | input | 1 | PC source: 0 ALU result, 1 branch-target register |
| addr_sel | input | 1 | Memory address: 0 PC, 1 held ALU result |
| ir_we | input | 1 | Instruction register write enable |
| tgt_we | input | 1 | Branch-target register write enable |
| ext_sign | input | 1 | Immediate extension: 1 sign, 0 zero |
| srca_sel | input | 1 | ALU A select |
| srcb_sel | input | 2 | ALU B select |
| alu_mode | input | 2 | ALU operation / function-field decode |
| rf_we | input | 1 | Register file write enable |
| rf_dst_rd | input | 1 | Write address: 1 rd, 0 rt |
| rf_from_mem | input | 1 | Write data: 1 memory read data, 0 held ALU result |
| mem_rdata | input | XLEN | Memory read data |
| mem_addr | output | XLEN | Memory byte address |
| mem_wdata | output | XLEN | Memory write data |
| opcode | output | 6 | Opcode of the held instruction |
| funct | output | 6 | Function field of the held instruction |
| zero | output | 1 | ALU result equals zero |

## Verification
The hardest case to reach is a branch whose target register must survive a cycle in which the ALU computes a different value.

The bench reaches it with an instruction sequence:
- It drives a branch-if-equal through decode.
- It inserts an extra cycle that recomputes PC+4 with the target write enable low.
- It then fires the conditional PC write, so that a wrong target register leads the next fetch address away from the expected one.

Register contents cannot be seen at the ports. They are brought out with store instructions and through the memory address during address calculation.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
  typedef enum logic [2:0] {
    FN_ADD,
    FN_SUB,
    FN_AND,
    FN_OR,
    FN_SLT
  } alu_fn_e;

  localparam logic [1:0] MODE_ADD   = 2'b00;
  localparam logic [1:0] MODE_SUB   = 2'b01;
  localparam logic [1:0] MODE_OR    = 2'b10;
  localparam logic [1:0] MODE_FIELD = 2'b11;

  localparam logic [5:0] FC_ADD = 6'h20;
  localparam logic [5:0] FC_SUB = 6'h22;
  localparam logic [5:0] FC_AND = 6'h24;
  localparam logic [5:0] FC_OR  = 6'h25;
  localparam logic [5:0] FC_SLT = 6'h2A;

  localparam logic [1:0] SRCB_FOUR = 2'b00;
  localparam logic [1:0] SRCB_REG  = 2'b01;
  localparam logic [1:0] SRCB_BOFS = 2'b10;
  localparam logic [1:0] SRCB_IMM  = 2'b11;

  localparam int REG_AW = 5;
  localparam int IMM_W  = 16;
endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  da,
  output logic [W-1:0]  db
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) store[wa] <= wd;
  end

  assign da = (ra == '0) ? '0 : store[ra];
  assign db = (rb == '0) ? '0 : store[rb];
endmodule

// File: rtl/mcdp_immgen.sv
module mcdp_immgen #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [IW-1:0] imm,
  input  logic          ext_sign,
  output logic [W-1:0]  ext,
  output logic [W-1:0]  ofs_x4
);
  localparam int PAD = W - IW;

  logic [W-1:0] sext;

  assign sext   = {{PAD{imm[IW-1]}}, imm};
  assign ext    = ext_sign ? sext : {{PAD{1'b0}}, imm};
  assign ofs_x4 = {sext[W-3:0], 2'b00};
endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   mode,
  input  logic [5:0]   fcode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  alu_fn_e fn;

  always_comb begin
    unique case (mode)
      MODE_ADD: fn = FN_ADD;
      MODE_SUB: fn = FN_SUB;
      MODE_OR:  fn = FN_OR;
      default: begin
        case (fcode)
          FC_SUB:  fn = FN_SUB;
          FC_AND:  fn = FN_AND;
          FC_OR:   fn = FN_OR;
          FC_SLT:  fn = FN_SLT;
          default: fn = FN_ADD;
        endcase
      end
    endcase
  end

  always_comb begin
    case (fn)
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcdp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_we,
  input  logic            pc_we_cond,
  input  logic            pc_src,
  input  logic            addr_sel,
  input  logic            ir_we,
  input  logic            tgt_we,
  input  logic            ext_sign,
  input  logic            srca_sel,
  input  logic [1:0]      srcb_sel,
  input  logic [1:0]      alu_mode,
  input  logic            rf_we,
  input  logic            rf_dst_rd,
  input  logic            rf_from_mem,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            zero
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_q, ir_q, tgt_q, opa_q, opb_q, res_q;
  logic [XLEN-1:0] rf_a, rf_b, imm_ext, imm_ofs;
  logic [XLEN-1:0] alu_a, alu_b, alu_y, wr_data;
  logic [REG_AW-1:0] rs_f, rt_f, rd_f, wr_addr;
  logic            pc_load;

  assign rs_f = ir_q[25:21];
  assign rt_f = ir_q[20:16];
  assign rd_f = ir_q[15:11];

  // instruction register and program counter
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (ir_we) ir_q <= mem_rdata;
      if (pc_load) pc_q <= pc_src ? tgt_q : alu_y;
    end
  end

  assign pc_load = pc_we | (pc_we_cond & zero);

  // branch target and per-cycle holding registers
  always_ff @(posedge clk) begin
    if (tgt_we) tgt_q <= alu_y;
    opa_q <= rf_a;
    opb_q <= rf_b;
    res_q <= alu_y;
  end

  assign wr_addr = rf_dst_rd ? rd_f : rt_f;
  assign wr_data = rf_from_mem ? mem_rdata : res_q;

  mcdp_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk (clk),
    .we  (rf_we),
    .wa  (wr_addr),
    .wd  (wr_data),
    .ra  (rs_f),
    .rb  (rt_f),
    .da  (rf_a),
    .db  (rf_b)
  );

  mcdp_immgen #(.W(XLEN), .IW(IMM_W)) u_imm (
    .imm      (ir_q[IMM_W-1:0]),
    .ext_sign (ext_sign),
    .ext      (imm_ext),
    .ofs_x4   (imm_ofs)
  );

  assign alu_a = srca_sel ? opa_q : pc_q;

  always_comb begin
    case (srcb_sel)
      SRCB_FOUR: alu_b = STEP;
      SRCB_REG:  alu_b = opb_q;
      SRCB_BOFS: alu_b = imm_ofs;
      default:   alu_b = imm_ext;
    endcase
  end

  mcdp_alu #(.W(XLEN)) u_alu (
    .mode  (alu_mode),
    .fcode (ir_q[5:0]),
    .a     (alu_a),
    .b     (alu_b),
    .y     (alu_y),
    .zero  (zero)
  );

  assign mem_addr  = addr_sel ? res_q : pc_q;
  assign mem_wdata = opb_q;
  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && ir_q == '0));

  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ir_we |=> $stable(ir_q));

  // R5
  tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tgt_we |=> $stable(tgt_q));

  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pc_we && !(pc_we_cond && zero)) |=> $stable(pc_q));

  // R6
  pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_we_cond && zero && pc_src) |=> (pc_q == $past(tgt_q)));

  // R11
  res_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (res_q == $past(alu_y)));
endmodule

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;
  logic        clk = 1'b0;
  logic        rst;
  logic        pc_we, pc_we_cond, pc_src, addr_sel, ir_we, tgt_we, ext_sign;
  logic        srca_sel, rf_we, rf_dst_rd, rf_from_mem;
  logic [1:0]  srcb_sel, alu_mode;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0]  opcode, funct;
  logic        zero;

  logic [31:0] mem [256];
  logic [31:0] rm  [32];
  logic [31:0] exp_pc, exp_tgt;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];

  mc_datapath dut (
    .clk(clk), .rst(rst), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
    .pc_src(pc_src), .addr_sel(addr_sel), .ir_we(ir_we), .tgt_we(tgt_we),
    .ext_sign(ext_sign), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
    .alu_mode(alu_mode), .rf_we(rf_we), .rf_dst_rd(rf_dst_rd),
    .rf_from_mem(rf_from_mem), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .opcode(opcode), .funct(funct), .zero(zero)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic clr();
    {pc_we, pc_we_cond, pc_src, addr_sel, ir_we, tgt_we, ext_sign} = '0;
    {srca_sel, rf_we, rf_dst_rd, rf_from_mem} = '0;
    srcb_sel = 2'b00;
    alu_mode = 2'b00;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] ref_alu(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2A:   return {31'b0, $signed(a) < $signed(b)};
      default: return a + b;
    endcase
  endfunction

  task automatic fetch_decode(input logic [31:0] instr);
    mem[exp_pc[9:2]] = instr;
    clr(); ir_we = 1; pc_we = 1;
    tick();
    exp_pc = exp_pc + 4;
    clr(); srcb_sel = 2'b10; tgt_we = 1;
    tick();
    exp_tgt = exp_pc + (sx(instr[15:0]) << 2);
  endtask

  task automatic t_ori(input int rt, input int rs, input logic [15:0] imm);
    logic [31:0] e;
    fetch_decode({6'h0D, 5'(rs), 5'(rt), imm});
    chk("R2 opcode held after decode", {26'b0, opcode}, 32'h0D);
    e = rm[rs] | {16'b0, imm};
    clr(); srca_sel = 1; srcb_sel = 2'b11; alu_mode = 2'b10; addr_sel = 1;
    tick();
    chk("R4/R11 ori zero-extended result", mem_addr, e);
    rf_we = 1;
    tick();
    if (rt != 0) rm[rt] = e;
  endtask

  task automatic t_r(input int rd, input int rs, input int rt, input logic [5:0] f);
    logic [31:0] e;
    fetch_decode({6'h00, 5'(rs), 5'(rt), 5'(rd), 5'b0, f});
    chk("R2 funct field", {26'b0, funct}, {26'b0, f});
    e = ref_alu(f, rm[rs], rm[rt]);
    clr(); srca_sel = 1; srcb_sel = 2'b01; alu_mode = 2'b11; addr_sel = 1;
    tick();
    chk($sformatf("R10 funct %h result", f), mem_addr, e);
    rf_we = 1; rf_dst_rd = 1;
    tick();
    if (rd != 0) rm[rd] = e;
  endtask

  task automatic t_lw(input int rt, input int rs, input logic [15:0] off);
    logic [31:0] a;
    fetch_decode({6'h23, 5'(rs), 5'(rt), off});
    a = rm[rs] + sx(off);
    clr(); srca_sel = 1; srcb_sel = 2'b11; ext_sign = 1; addr_sel = 1;
    tick();
    chk("R4/R8 load address sign-extended", mem_addr, a);
    tick();
    rf_we = 1; rf_from_mem = 1;
    tick();
    if (rt != 0) rm[rt] = mem[a[9:2]];
  endtask

  task automatic t_sw(input int rt, input int rs, input logic [15:0] off);
    logic [31:0] a;
    fetch_decode({6'h2B, 5'(rs), 5'(rt), off});
    a = rm[rs] + sx(off);
    clr(); srca_sel = 1; srcb_sel = 2'b11; ext_sign = 1; addr_sel = 1;
    tick();
    chk("R8 store address", mem_addr, a);
    chk("R7/R8 store data is rt", mem_wdata, rm[rt]);
    tick();
    mem[a[9:2]] = mem_wdata;
  endtask

  task automatic t_beq(input int rs, input int rt, input logic [15:0] off, input bit extra);
    logic taken;
    fetch_decode({6'h04, 5'(rs), 5'(rt), off});
    if (extra) begin
      clr();
      tick();
    end
    taken = (rm[rs] == rm[rt]);
    clr(); srca_sel = 1; srcb_sel = 2'b01; alu_mode = 2'b01; pc_we_cond = 1; pc_src = 1;
    #2;
    chk("R10 zero flag on compare", {31'b0, zero}, {31'b0, taken});
    tick();
    if (taken) exp_pc = exp_tgt;
    clr();
    #1;
    chk(extra ? "R5/R6 branch target survives extra cycle" : "R6 conditional PC write",
        mem_addr, exp_pc);
  endtask

  task automatic t_reset();
    clr(); rst = 1;
    tick(); tick();
    rst = 0;
    #1;
    chk("R1 PC cleared", mem_addr, 32'h0);
    chk("R1 opcode cleared", {26'b0, opcode}, 32'h0);
    chk("R1 funct cleared", {26'b0, funct}, 32'h0);
    exp_pc = 0;
  endtask

  task automatic t_srcsel(input int rt);
    clr(); srca_sel = 0; srcb_sel = 2'b01; addr_sel = 1;
    tick();
    chk("R3 A=PC B=operand B", mem_addr, exp_pc + rm[rt]);
    clr(); srca_sel = 1; srcb_sel = 2'b00; addr_sel = 1;
    tick();
    chk("R3 A=operand A B=four", mem_addr, 32'h4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 32; i++) rm[i] = '0;
    mem[65] = 32'hCAFE_F00D;
    exp_pc = 0; exp_tgt = 0;
    @(negedge clk);
    t_reset();
    t_ori(1, 0, 16'h8001);
    t_ori(2, 0, 16'h00FF);
    t_r(3, 1, 2, 6'h20);
    t_r(4, 1, 2, 6'h22);
    t_r(5, 1, 2, 6'h24);
    t_r(6, 1, 2, 6'h25);
    t_r(7, 2, 1, 6'h2A);
    t_r(8, 1, 2, 6'h2A);
    chk("R7 rt unchanged by R-type writing rd", rm[2], 32'hFF);
    t_ori(0, 0, 16'h5555);
    t_r(9, 0, 2, 6'h20);   // R9: r0 must still read zero
    t_sw(3, 0, 16'h0100);
    chk("R8 stored word in memory", mem[64], 32'h8100);
    t_lw(10, 0, 16'h0100);
    t_sw(10, 0, 16'h0108);
    chk("R7 load wrote rt from memory", mem[66], 32'h8100);
    t_ori(11, 0, 16'h0110);
    t_lw(12, 11, 16'hFFF4);
    t_sw(12, 0, 16'h010C);
    chk("R4 negative offset load", mem[67], 32'hCAFE_F00D);
    t_srcsel(12);
    t_beq(1, 2, 16'h0003, 0);
    t_beq(3, 10, 16'h0002, 1);
    t_ori(13, 0, 16'h0042);
    finish_run();
  end
endmodule